// File: doc/BRIEF.md
# MRU Line Refresh Buffer Manager

This block decides what happens to a cache line in a 16-way set when the line reaches the end of its retention window. Each expiry event carries the line's set, way, replacement position (0 is the most recently used), dirty flag and data. A line counts as important when its position is among the top `MRU_KEEP` positions. An important line is copied into a small side buffer if the buffer has room. Lines that are not important, and important lines that find the buffer full, are handled in one of two ways. A dirty line is sent to main memory as a write-back request. A clean line is invalidated with no memory traffic.

The buffer drains in arrival order through a rewrite port back to the original set and way. Each rewrite restores the line's retention. The array accepts a rewrite by raising a grant. If the processor writes a line while a copy of it sits in the buffer, that copy is discarded, so stale data never overwrites the fresh line. Keeping the replacement state up to date is left to the surrounding cache.

Top module: `mru_refresh_mgr`

## Requirements
- R1: An expiry is important exactly when `exp_lru_pos < MRU_KEEP`, where position 0 is the most recently used. With room in the buffer, an important expiry is buffered and causes neither a write-back nor an invalidate.
- R2: A buffered line is presented on the rewrite port from the cycle after its expiry, with its set, way, data and dirty flag. The rewrite port shows the oldest live entry.
- R3: Buffered lines leave the buffer in first-in first-out order. The head entry is removed on each cycle in which `rw_valid` and `rw_grant` are both high.
- R4: A non-important dirty expiry raises `wb_valid` for exactly one cycle, the cycle after the expiry, with the line's set, way and data.
- R5: A non-important clean expiry raises `inv_valid` for exactly one cycle, the cycle after the expiry, with its set and way, and raises no write-back.
- R6: When the buffer holds `DEPTH` entries, an important dirty expiry produces a write-back and an important clean expiry produces an invalidate. The buffer contents stay unchanged.
- R7: A processor write (`cpu_wr_valid`) to a set and way that has a live buffered copy discards that copy, and the copy is never rewritten. In the cycle of that write, a matching head entry is not offered on the rewrite port. An expiry and a processor write to the same line in the same cycle store nothing live.
- R8: After reset the buffer is empty and `rw_valid`, `wb_valid` and `inv_valid` are low.
- R9: Each expiry has exactly one outcome: it is buffered, it is written back, or it is invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_valid | input | 1 | Expiry event this cycle |
| exp_set | input | SET_W | Set of the expiring line |
| exp_way | input | WAY_W | Way of the expiring line (0 to NUM_WAYS-1) |
| exp_lru_pos | input | WAY_W | Replacement position, 0 = most recently used |
| exp_dirty | input | 1 | Expiring line is dirty |
| exp_data | input | DATA_W | Contents of the expiring line |
| cpu_wr_valid | input | 1 | Processor write to a line this cycle |
| cpu_wr_set | input | SET_W | Set of the processor write |
| cpu_wr_way | input | WAY_W | Way of the processor write |
| rw_grant | input | 1 | Array accepts the offered rewrite |
| rw_valid | output | 1 | Rewrite offered |
| rw_set | output | SET_W | Rewrite set |
| rw_way | output | WAY_W | Rewrite way |
| rw_data | output | DATA_W | Rewrite data |
| rw_dirty | output | 1 | Dirty flag kept by the rewritten line |
| wb_valid | output | 1 | Write-back request pulse |
| wb_set | output | SET_W | Write-back set |
| wb_way | output | WAY_W | Write-back way |
| wb_data | output | DATA_W | Write-back data |
| inv_valid | output | 1 | Invalidate pulse |
| inv_set | output | SET_W | Invalidate set |
| inv_way | output | WAY_W | Invalidate way |

## Verification
The bench builds the block with `DEPTH` = 2 and `MRU_KEEP` = 3, keeping 16 ways. A depth of two lets two expiries fill the buffer, so the full-buffer fallbacks for both dirty and clean lines are reached quickly. The importance boundary falls between positions 2 and 3, which tests both sides of the comparison at a value other than the default. Way 15 and position 15 exercise the top of the way range. Processor writes that hit the head entry and a non-head entry show that a discarded copy is skipped without ever reaching the rewrite port.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

    typedef enum logic [1:0] {
        DEC_NONE      = 2'd0,
        DEC_BUFFER    = 2'd1,
        DEC_WRITEBACK = 2'd2,
        DEC_DROP      = 2'd3
    } decision_e;

    function automatic decision_e decide(input logic valid,
                                         input logic important,
                                         input logic full,
                                         input logic dirty);
        decision_e d;
        if (!valid)                 d = DEC_NONE;
        else if (important && !full) d = DEC_BUFFER;
        else if (dirty)             d = DEC_WRITEBACK;
        else                        d = DEC_DROP;
        return d;
    endfunction

endpackage

// File: rtl/mrl_classify.sv
module mrl_classify #(
    parameter int NUM_WAYS = 16,
    parameter int MRU_KEEP = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                 exp_valid,
    input  logic [WAY_W-1:0]     exp_lru_pos,
    input  logic                 exp_dirty,
    input  logic                 buf_full,
    output mrl_pkg::decision_e   decision
);
    import mrl_pkg::*;

    logic important;

    always_comb begin
        important = ({1'b0, exp_lru_pos} < (WAY_W+1)'(MRU_KEEP));
        decision  = decide(exp_valid, important, buf_full, exp_dirty);
    end

    always_comb begin
        if (exp_valid) begin
            a_r9_one_outcome: assert (decision != DEC_NONE);
        end
    end

endmodule

// File: rtl/mrl_fifo.sv
module mrl_fifo #(
    parameter int DEPTH  = 4,
    parameter int SET_W  = 6,
    parameter int WAY_W  = 4,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [SET_W-1:0]  push_set,
    input  logic [WAY_W-1:0]  push_way,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_dirty,
    input  logic              push_live,
    input  logic              kill_valid,
    input  logic [SET_W-1:0]  kill_set,
    input  logic [WAY_W-1:0]  kill_way,
    input  logic              pop_grant,
    output logic              full,
    output logic              head_valid,
    output logic [SET_W-1:0]  head_set,
    output logic [WAY_W-1:0]  head_way,
    output logic [DATA_W-1:0] head_data,
    output logic              head_dirty
);
    logic [SET_W-1:0]  ent_set   [DEPTH];
    logic [WAY_W-1:0]  ent_way   [DEPTH];
    logic [DATA_W-1:0] ent_data  [DEPTH];
    logic              ent_dirty [DEPTH];
    logic [DEPTH-1:0]  ent_live;
    logic [DEPTH-1:0]  kill_vec;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              nonempty, head_live, head_hit, pop;

    for (genvar i = 0; i < DEPTH; i++) begin : g_kill
        assign kill_vec[i] = kill_valid && ent_live[i] &&
                             (ent_set[i] == kill_set) && (ent_way[i] == kill_way);
    end

    always_comb begin
        nonempty   = (count != '0);
        full       = (count == CNT_W'(DEPTH));
        head_live  = ent_live[rd_ptr];
        head_hit   = kill_vec[rd_ptr];
        head_valid = nonempty && head_live && !head_hit;
        head_set   = ent_set[rd_ptr];
        head_way   = ent_way[rd_ptr];
        head_data  = ent_data[rd_ptr];
        head_dirty = ent_dirty[rd_ptr];
        pop        = (head_valid && pop_grant) || (nonempty && !head_live);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            ent_live <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_set[i]   <= '0;
                ent_way[i]   <= '0;
                ent_data[i]  <= '0;
                ent_dirty[i] <= 1'b0;
            end
        end else begin
            ent_live <= ent_live & ~kill_vec;
            if (pop) begin
                ent_live[rd_ptr] <= 1'b0;
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (push) begin
                ent_set[wr_ptr]   <= push_set;
                ent_way[wr_ptr]   <= push_way;
                ent_data[wr_ptr]  <= push_data;
                ent_dirty[wr_ptr] <= push_dirty;
                ent_live[wr_ptr]  <= push_live;
                wr_ptr <= wr_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        (pop_grant && head_valid) |=> (count != CNT_W'(DEPTH)) || $past(push));

    a_r7_no_stale_offer: assert property (@(posedge clk) disable iff (rst)
        (kill_valid && nonempty && head_set == kill_set && head_way == kill_way && head_live)
        |-> !head_valid);

endmodule

// File: rtl/mrl_outreg.sv
module mrl_outreg #(
    parameter int SET_W  = 6,
    parameter int WAY_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  mrl_pkg::decision_e decision,
    input  logic [SET_W-1:0]   in_set,
    input  logic [WAY_W-1:0]   in_way,
    input  logic [DATA_W-1:0]  in_data,
    output logic               wb_valid,
    output logic [SET_W-1:0]   wb_set,
    output logic [WAY_W-1:0]   wb_way,
    output logic [DATA_W-1:0]  wb_data,
    output logic               inv_valid,
    output logic [SET_W-1:0]   inv_set,
    output logic [WAY_W-1:0]   inv_way
);
    import mrl_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid  <= 1'b0;
            wb_set    <= '0;
            wb_way    <= '0;
            wb_data   <= '0;
            inv_valid <= 1'b0;
            inv_set   <= '0;
            inv_way   <= '0;
        end else begin
            wb_valid  <= (decision == DEC_WRITEBACK);
            inv_valid <= (decision == DEC_DROP);
            if (decision == DEC_WRITEBACK) begin
                wb_set  <= in_set;
                wb_way  <= in_way;
                wb_data <= in_data;
            end
            if (decision == DEC_DROP) begin
                inv_set <= in_set;
                inv_way <= in_way;
            end
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_valid, inv_valid}));

endmodule

// File: rtl/mru_refresh_mgr.sv
module mru_refresh_mgr #(
    parameter int NUM_WAYS = 16,
    parameter int SET_W    = 6,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 4,
    parameter int MRU_KEEP = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exp_valid,
    input  logic [SET_W-1:0]  exp_set,
    input  logic [WAY_W-1:0]  exp_way,
    input  logic [WAY_W-1:0]  exp_lru_pos,
    input  logic              exp_dirty,
    input  logic [DATA_W-1:0] exp_data,
    input  logic              cpu_wr_valid,
    input  logic [SET_W-1:0]  cpu_wr_set,
    input  logic [WAY_W-1:0]  cpu_wr_way,
    input  logic              rw_grant,
    output logic              rw_valid,
    output logic [SET_W-1:0]  rw_set,
    output logic [WAY_W-1:0]  rw_way,
    output logic [DATA_W-1:0] rw_data,
    output logic              rw_dirty,
    output logic              wb_valid,
    output logic [SET_W-1:0]  wb_set,
    output logic [WAY_W-1:0]  wb_way,
    output logic [DATA_W-1:0] wb_data,
    output logic              inv_valid,
    output logic [SET_W-1:0]  inv_set,
    output logic [WAY_W-1:0]  inv_way
);
    import mrl_pkg::*;

    decision_e decision;
    logic      buf_full;
    logic      push, push_live;

    mrl_classify #(.NUM_WAYS(NUM_WAYS), .MRU_KEEP(MRU_KEEP)) u_classify (
        .exp_valid  (exp_valid),
        .exp_lru_pos(exp_lru_pos),
        .exp_dirty  (exp_dirty),
        .buf_full   (buf_full),
        .decision   (decision)
    );

    always_comb begin
        push      = (decision == DEC_BUFFER);
        push_live = !(cpu_wr_valid && cpu_wr_set == exp_set && cpu_wr_way == exp_way);
    end

    mrl_fifo #(.DEPTH(DEPTH), .SET_W(SET_W), .WAY_W(WAY_W), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_set  (exp_set),
        .push_way  (exp_way),
        .push_data (exp_data),
        .push_dirty(exp_dirty),
        .push_live (push_live),
        .kill_valid(cpu_wr_valid),
        .kill_set  (cpu_wr_set),
        .kill_way  (cpu_wr_way),
        .pop_grant (rw_grant),
        .full      (buf_full),
        .head_valid(rw_valid),
        .head_set  (rw_set),
        .head_way  (rw_way),
        .head_data (rw_data),
        .head_dirty(rw_dirty)
    );

    mrl_outreg #(.SET_W(SET_W), .WAY_W(WAY_W), .DATA_W(DATA_W)) u_outreg (
        .clk      (clk),
        .rst      (rst),
        .decision (decision),
        .in_set   (exp_set),
        .in_way   (exp_way),
        .in_data  (exp_data),
        .wb_valid (wb_valid),
        .wb_set   (wb_set),
        .wb_way   (wb_way),
        .wb_data  (wb_data),
        .inv_valid(inv_valid),
        .inv_set  (inv_set),
        .inv_way  (inv_way)
    );

    a_r4_wb_from_dirty: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(exp_valid && exp_dirty));

    a_r5_inv_from_clean: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> $past(exp_valid && !exp_dirty));

    a_r1_important_kept: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && !buf_full && ({1'b0, exp_lru_pos} < (WAY_W+1)'(MRU_KEEP)))
        |=> !wb_valid && !inv_valid);

endmodule

// File: tb/mru_refresh_mgr_tb.sv
module mru_refresh_mgr_tb;
    localparam int SET_W = 6, DATA_W = 32, WAY_W = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic exp_valid = 0, exp_dirty = 0, cpu_wr_valid = 0, rw_grant = 0;
    logic [SET_W-1:0] exp_set = 0, cpu_wr_set = 0;
    logic [WAY_W-1:0] exp_way = 0, exp_lru_pos = 0, cpu_wr_way = 0;
    logic [DATA_W-1:0] exp_data = 0;
    logic rw_valid, rw_dirty, wb_valid, inv_valid;
    logic [SET_W-1:0] rw_set, wb_set, inv_set;
    logic [WAY_W-1:0] rw_way, wb_way, inv_way;
    logic [DATA_W-1:0] rw_data, wb_data;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    mru_refresh_mgr #(.NUM_WAYS(16), .SET_W(SET_W), .DATA_W(DATA_W),
                      .DEPTH(2), .MRU_KEEP(3)) u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expire(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w,
                          input logic [WAY_W-1:0] pos, input logic d,
                          input logic [DATA_W-1:0] dat);
        @(negedge clk);
        exp_valid = 1; exp_set = s; exp_way = w; exp_lru_pos = pos;
        exp_dirty = d; exp_data = dat;
        @(negedge clk);
        exp_valid = 0;
    endtask

    task automatic t_reset();
        chk("R8 rw_valid", rw_valid, 0);
        chk("R8 wb_valid", wb_valid, 0);
        chk("R8 inv_valid", inv_valid, 0);
    endtask

    task automatic t_buffer_and_full();
        expire(5, 15, 0, 0, 32'hA1);
        chk("R1 wb after important", wb_valid, 0);
        chk("R1 inv after important", inv_valid, 0);
        chk("R2 rw_valid", rw_valid, 1);
        chk("R2 rw_set", rw_set, 5);
        chk("R2 rw_way", rw_way, 15);
        chk("R2 rw_data", rw_data, 32'hA1);
        chk("R2 rw_dirty", rw_dirty, 0);
        expire(6, 2, 2, 1, 32'hB2);
        chk("R1 pos2 no wb", wb_valid, 0);
        chk("R1 pos2 no inv", inv_valid, 0);
        chk("R2 head kept", rw_data, 32'hA1);
        expire(7, 3, 0, 1, 32'hC3);
        chk("R6 full dirty wb", wb_valid, 1);
        chk("R6 full wb_data", wb_data, 32'hC3);
        chk("R6 full wb_set", wb_set, 7);
        chk("R6 full wb_way", wb_way, 3);
        expire(7, 4, 1, 0, 32'hC4);
        chk("R6 full clean inv", inv_valid, 1);
        chk("R6 full clean no wb", wb_valid, 0);
        chk("R6 head unchanged", rw_data, 32'hA1);
    endtask

    task automatic t_drain();
        rw_grant = 1;
        @(negedge clk);
        chk("R3 second valid", rw_valid, 1);
        chk("R3 second data", rw_data, 32'hB2);
        chk("R3 second set", rw_set, 6);
        chk("R3 second way", rw_way, 2);
        chk("R3 second dirty", rw_dirty, 1);
        @(negedge clk);
        chk("R3 empty after drain", rw_valid, 0);
        rw_grant = 0;
    endtask

    task automatic t_not_important();
        expire(9, 8, 3, 1, 32'hD4);
        chk("R4 wb_valid", wb_valid, 1);
        chk("R4 wb_data", wb_data, 32'hD4);
        chk("R4 wb_set", wb_set, 9);
        chk("R4 wb_way", wb_way, 8);
        chk("R1 pos3 not buffered", rw_valid, 0);
        expire(9, 9, 15, 0, 32'hD5);
        chk("R5 inv_valid", inv_valid, 1);
        chk("R5 inv_set", inv_set, 9);
        chk("R5 inv_way", inv_way, 9);
        chk("R5 no wb", wb_valid, 0);
        @(negedge clk);
        chk("R5 inv one cycle", inv_valid, 0);
        chk("R5 still empty", rw_valid, 0);
    endtask

    task automatic t_kill_head();
        expire(1, 1, 0, 0, 32'hE5);
        expire(2, 2, 1, 0, 32'hF6);
        cpu_wr_valid = 1; cpu_wr_set = 1; cpu_wr_way = 1;
        #1;
        chk("R7 head hidden in write cycle", rw_valid, 0);
        @(negedge clk);
        cpu_wr_valid = 0;
        chk("R7 dead head not offered", rw_valid, 0);
        @(negedge clk);
        chk("R7 next entry valid", rw_valid, 1);
        chk("R7 next entry data", rw_data, 32'hF6);
        rw_grant = 1;
        @(negedge clk);
        rw_grant = 0;
        chk("R7 empty after", rw_valid, 0);
    endtask

    task automatic t_kill_tail();
        expire(3, 3, 0, 0, 32'h11);
        expire(4, 4, 0, 0, 32'h22);
        cpu_wr_valid = 1; cpu_wr_set = 4; cpu_wr_way = 4;
        @(negedge clk);
        cpu_wr_valid = 0;
        chk("R7 head intact", rw_data, 32'h11);
        rw_grant = 1;
        @(negedge clk);
        chk("R7 discarded tail skipped", rw_valid, 0);
        @(negedge clk);
        chk("R7 buffer empty", rw_valid, 0);
        rw_grant = 0;
        expire(4, 5, 1, 1, 32'h33);
        chk("R2 reuse after skip", rw_data, 32'h33);
        chk("R2 reuse dirty", rw_dirty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_buffer_and_full();
        t_drain();
        t_not_important();
        t_kill_head();
        t_kill_tail();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule